// File: doc/BRIEF.md
# PLL Loss-of-Lock Status Register

This block is the status word of a clock synthesizer as software sees it. It gathers the lock monitor's indicators into one 32-bit read-only word on a simple register port. It also keeps a sticky loss-of-lock flag that drives an interrupt request. The flag records only lock losses that nothing in the system caused on purpose. Three kinds of event are expected to knock the loop out of lock: a system reset, a rewrite of the multiplier or predivider setting, and switching on frequency modulation. Each of these opens an "expected unlock" window. A drop of lock inside that window is ignored. The window closes the next time lock comes back.

Software reads the word at its offset and acknowledges the flag by writing a 1 to its bit. It acknowledges the loss-of-clock flag the same way. The mode, PLL-select and reference-select bits are strap values captured while reset is held, and writes do not change them. The lock detector, the analog loop, calibration and the control register are outside this block. It only receives their indications as inputs.

Top module: `pll_lock_status`

## Requirements
- R1: A read at offset 0x4 returns the status word one clock after the address is presented, with bits 31:10 always zero. A read at any other offset returns zero.
- R2: Status word bit positions, LSB = 0: cal pass 0, cal done 1, loss-of-clock flag 2, current lock 3, sticky lock 4, reference select 5, PLL select 6, mode 7, raw loss-of-clock 8, loss-of-lock flag 9.
- R3: A high-to-low change of `lock_in` that is not expected, seen while `lol_irq_en` is 1, sets the loss-of-lock flag. The flag is visible on `lol_irq_o` after the first clock edge at which `lock_in` is sampled low following a high sample.
- R4: With `lol_irq_en` at 0, a drop of lock never sets the flag.
- R5: The expected-unlock window opens at reset, on a `ratio_wr` pulse and on an `fm_on` pulse, including a pulse in the same cycle as the drop. It closes on the next rise of `lock_in`. A drop inside the window does not set the flag.
- R6: Once set, the flag stays set after lock returns and through `ratio_wr` or `fm_on` pulses.
- R7: Writing 1 to bit 9 at offset 0x4 clears the loss-of-lock flag. Writing 0 to that bit has no effect, and neither does writing 1 to bit 9 at any other offset.
- R8: When a set and a write-1 clear of the loss-of-lock flag fall in the same cycle, the flag ends up set.
- R9: `lol_irq_o` is high exactly when the loss-of-lock flag is set, and it matches bit 9 of the word.
- R10: The loss-of-clock flag (bit 2) sets on a rise of `loc_in`. Writing 1 to bit 2 clears it, and writing 0 leaves it. Bit 8 follows `loc_in` one clock late.
- R11: Sticky lock (bit 4) sets on the first lock rise after reset. Any unexpected drop clears it, whatever the enable is, and it then stays 0 until reset. Bit 3 follows `lock_in` one clock late.
- R12: Mode, PLL-select and reference-select bits hold the strap inputs as sampled while `rst` was high. They ignore later strap changes and all writes.
- R13: Synchronous active-high `rst` clears both flags and drives `lol_irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (write-1-to-clear on bits 9 and 2) |
| bus_rdata | output | 32 | Registered read data |
| lock_in | input | 1 | Raw lock indication |
| loc_in | input | 1 | Raw loss-of-clock indication |
| lol_irq_en | input | 1 | Loss-of-lock interrupt enable |
| ratio_wr | input | 1 | Pulse: multiplier or predivider rewritten |
| fm_on | input | 1 | Pulse: frequency modulation enabled |
| strap_mode | input | 1 | Mode strap, captured during reset |
| strap_pll_sel | input | 1 | PLL-select strap, captured during reset |
| strap_ref_sel | input | 1 | Reference-select strap, captured during reset |
| cal_done_in | input | 1 | Calibration done indication |
| cal_pass_in | input | 1 | Calibration pass indication |
| lol_irq_o | output | 1 | Loss-of-lock interrupt request |

## Verification
The bench targets drops of lock that land in the same cycle as a ratio or modulation pulse. A design that honoured only an already-open window would raise a spurious interrupt there. It also checks drops that come after a pulse but before relock, which catches a window that closes too early. It pairs a set with a same-cycle acknowledge, where the wrong priority loses an interrupt. It checks that pulses arriving after a real failure leave the flag in place, which catches a design that treats those pulses as clears. Acknowledge writes with a 0 bit or a wrong offset, straps changed after reset, and the sticky-lock bit after a drop with the interrupt disabled round out the corner cases.

// File: rtl/pll_ls_pkg.sv
package pll_ls_pkg;
  localparam int REG_W       = 32;
  localparam int USED_BITS   = 10;
  localparam int BIT_CALPASS = 0;
  localparam int BIT_CALDONE = 1;
  localparam int BIT_LOCF    = 2;
  localparam int BIT_LOCK    = 3;
  localparam int BIT_LOCKS   = 4;
  localparam int BIT_REFSEL  = 5;
  localparam int BIT_PLLSEL  = 6;
  localparam int BIT_MODE    = 7;
  localparam int BIT_LOC     = 8;
  localparam int BIT_LOLF    = 9;

  typedef struct packed {
    logic mode;
    logic pll_sel;
    logic ref_sel;
  } strap_t;
endpackage

// File: rtl/pll_ls_edge.sv
// Registered copy of a level input with rise / fall pulses.
module pll_ls_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic sig_q,
  output logic rise_o,
  output logic fall_o
);
  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/pll_ls_window.sv
// Tracks the "expected unlock" window.
module pll_ls_window (
  input  logic clk,
  input  logic rst,
  input  logic ratio_wr_i,
  input  logic fm_on_i,
  input  logic lock_rise_i,
  output logic open_q,
  output logic suppress_o
);
  logic strobe;
  assign strobe     = ratio_wr_i | fm_on_i;
  assign suppress_o = open_q | strobe;

  always_ff @(posedge clk) begin
    if (rst)              open_q <= 1'b1;
    else if (strobe)      open_q <= 1'b1;
    else if (lock_rise_i) open_q <= 1'b0;
  end

  // R5: a suppressing pulse leaves the window open next cycle
  a_r5_strobe_opens: assert property (@(posedge clk) disable iff (rst)
    strobe |=> open_q);
  // R5: relock without a new pulse closes the window
  a_r5_relock_closes: assert property (@(posedge clk) disable iff (rst)
    (lock_rise_i && !strobe) |=> !open_q);
endmodule

// File: rtl/pll_ls_flag.sv
// Sticky write-1-to-clear flag; set has priority over clear.
module pll_ls_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  // R6: without a clear the flag holds
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
  // R8: simultaneous set and clear leaves the flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_q);
  // R7: a clear with no set drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/pll_lock_status.sv
module pll_lock_status
  import pll_ls_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STAT_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              lock_in,
  input  logic              loc_in,
  input  logic              lol_irq_en,
  input  logic              ratio_wr,
  input  logic              fm_on,
  input  logic              strap_mode,
  input  logic              strap_pll_sel,
  input  logic              strap_ref_sel,
  input  logic              cal_done_in,
  input  logic              cal_pass_in,
  output logic              lol_irq_o
);
  localparam logic [ADDR_W-1:0] OFF = STAT_OFFSET[ADDR_W-1:0];

  logic   lock_q, lock_rise, lock_fall;
  logic   loc_q, loc_rise, loc_fall;
  logic   win_open, suppress;
  logic   lolf_q, locf_q;
  logic   locks_q, lost_q;
  logic   sel, wr_hit, lol_set, unexp_fall;
  strap_t strap_q;
  logic [REG_W-1:0] word;

  pll_ls_edge u_lock_edge (
    .clk(clk), .rst(rst), .sig_i(lock_in),
    .sig_q(lock_q), .rise_o(lock_rise), .fall_o(lock_fall));

  pll_ls_edge u_loc_edge (
    .clk(clk), .rst(rst), .sig_i(loc_in),
    .sig_q(loc_q), .rise_o(loc_rise), .fall_o(loc_fall));

  pll_ls_window u_window (
    .clk(clk), .rst(rst), .ratio_wr_i(ratio_wr), .fm_on_i(fm_on),
    .lock_rise_i(lock_rise), .open_q(win_open), .suppress_o(suppress));

  assign sel        = (bus_addr == OFF);
  assign wr_hit     = bus_wr & sel;
  assign unexp_fall = lock_fall & ~suppress;
  assign lol_set    = unexp_fall & lol_irq_en;

  pll_ls_flag u_lol_flag (
    .clk(clk), .rst(rst), .set_i(lol_set),
    .clr_i(wr_hit & bus_wdata[BIT_LOLF]), .flag_q(lolf_q));

  pll_ls_flag u_loc_flag (
    .clk(clk), .rst(rst), .set_i(loc_rise),
    .clr_i(wr_hit & bus_wdata[BIT_LOCF]), .flag_q(locf_q));

  // Sticky lock: first acquisition after reset, lost for good on a real drop
  always_ff @(posedge clk) begin
    if (rst) begin
      locks_q <= 1'b0;
      lost_q  <= 1'b0;
    end else if (unexp_fall) begin
      locks_q <= 1'b0;
      lost_q  <= 1'b1;
    end else if (lock_rise && !lost_q) begin
      locks_q <= 1'b1;
    end
  end

  // Straps are loaded only while reset is held
  always_ff @(posedge clk) begin
    if (rst) strap_q <= '{mode: strap_mode, pll_sel: strap_pll_sel, ref_sel: strap_ref_sel};
  end

  always_comb begin
    word              = '0;
    word[BIT_CALPASS] = cal_pass_in;
    word[BIT_CALDONE] = cal_done_in;
    word[BIT_LOCF]    = locf_q;
    word[BIT_LOCK]    = lock_q;
    word[BIT_LOCKS]   = locks_q;
    word[BIT_REFSEL]  = strap_q.ref_sel;
    word[BIT_PLLSEL]  = strap_q.pll_sel;
    word[BIT_MODE]    = strap_q.mode;
    word[BIT_LOC]     = loc_q;
    word[BIT_LOLF]    = lolf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= sel ? word : '0;
  end

  assign lol_irq_o = lolf_q;

  // R1: reserved bits never read as one
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[REG_W-1:USED_BITS] == '0);
  // R4: no set while the enable is low
  a_r4_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (lock_fall && !lol_irq_en && !lolf_q) |=> !lolf_q);
  // R5: an expected drop never sets the flag
  a_r5_expected_drop: assert property (@(posedge clk) disable iff (rst)
    (lock_fall && suppress && !lolf_q) |=> !lolf_q);
  // R9: read-back of bit 9 follows the flag
  a_r9_readback: assert property (@(posedge clk) disable iff (rst)
    sel |=> (bus_rdata[BIT_LOLF] == $past(lolf_q)));
  // R11: once lost, sticky lock stays low
  a_r11_locks_low: assert property (@(posedge clk) disable iff (rst)
    (lost_q && !locks_q) |=> !locks_q);
  // R12: straps stay fixed outside reset
  a_r12_straps_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_q));
endmodule

// File: tb/pll_lock_status_tb.sv
module pll_lock_status_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h04;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lock_in = 1'b0, loc_in = 1'b0, lol_irq_en = 1'b1;
  logic        ratio_wr = 1'b0, fm_on = 1'b0;
  logic        strap_mode = 1'b1, strap_pll_sel = 1'b0, strap_ref_sel = 1'b1;
  logic        cal_done_in = 1'b1, cal_pass_in = 1'b0;
  logic        lol_irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pll_lock_status dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in),
    .loc_in(loc_in), .lol_irq_en(lol_irq_en), .ratio_wr(ratio_wr),
    .fm_on(fm_on), .strap_mode(strap_mode), .strap_pll_sel(strap_pll_sel),
    .strap_ref_sel(strap_ref_sel), .cal_done_in(cal_done_in),
    .cal_pass_in(cal_pass_in), .lol_irq_o(lol_irq_o));

  // {lock, enable, ratio_wr, fm_on, ack, expected irq}
  localparam logic [5:0] VEC [0:19] = '{
    6'b110000, // R3 relock after reset closes window
    6'b010001, // R3 unexpected drop
    6'b110001, // R6 relock keeps flag
    6'b111001, // R6 ratio pulse keeps flag
    6'b110010, // R7 ack
    6'b010000, // R5 drop after ratio pulse
    6'b110000, // R5 relock closes
    6'b000000, // R4 drop with enable low
    6'b110000,
    6'b110100, // R5 fm pulse
    6'b010000, // R5 drop after fm pulse
    6'b110000,
    6'b011000, // R5 drop with ratio pulse same cycle
    6'b110000,
    6'b010100, // R5 drop with fm pulse same cycle
    6'b110000,
    6'b010011, // R8 set and ack together
    6'b110101, // R6 fm pulse keeps flag
    6'b110010, // R7 ack
    6'b110000
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    tick();
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_wdata = '0; bus_addr = 8'h04;
  endtask

  initial begin
    logic [31:0] d;
    #2;
    do_reset();
    strap_mode = 1'b0; strap_pll_sel = 1'b1; strap_ref_sel = 1'b0;
    chk("R13 irq after reset", {31'd0, lol_irq_o}, 32'd0);
    rd(8'h04, d); chk("R2 R12 reset word", d, 32'h0000_00A2);
    rd(8'h08, d); chk("R1 other offset", d, 32'd0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R12 writes ignored", d, 32'h0000_00A2);

    lock_in = 1'b1; tick();
    rd(8'h04, d); chk("R11 sticky lock set", d, 32'h0000_00BA);
    loc_in = 1'b1; tick();
    rd(8'h04, d); chk("R10 loc flag set", d, 32'h0000_01BE);
    wr(8'h04, 32'd0);
    rd(8'h04, d); chk("R10 write zero", d, 32'h0000_01BE);
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, d); chk("R10 ack", d, 32'h0000_01BA);

    lock_in = 1'b0; loc_in = 1'b0;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      lock_in    = VEC[i][5];
      lol_irq_en = VEC[i][4];
      ratio_wr   = VEC[i][3];
      fm_on      = VEC[i][2];
      bus_addr   = 8'h04;
      bus_wr     = VEC[i][1];
      bus_wdata  = VEC[i][1] ? 32'h0000_0200 : 32'd0;
      tick();
      chk($sformatf("R3-table step %0d irq", i), {31'd0, lol_irq_o}, {31'd0, VEC[i][0]});
    end
    ratio_wr = 1'b0; fm_on = 1'b0; bus_wr = 1'b0; bus_wdata = '0; lol_irq_en = 1'b1;
    rd(8'h04, d); chk("R11 sticky lock lost", d, 32'h0000_004A);

    lock_in = 1'b0; tick();
    chk("R5 drop inside open window", {31'd0, lol_irq_o}, 32'd0);
    lock_in = 1'b1; tick();
    lock_in = 1'b0; tick();
    chk("R3 drop after relock", {31'd0, lol_irq_o}, 32'd1);
    wr(8'h04, 32'd0);
    chk("R7 write zero", {31'd0, lol_irq_o}, 32'd1);
    wr(8'h08, 32'h0000_0200);
    chk("R7 wrong offset", {31'd0, lol_irq_o}, 32'd1);
    rd(8'h04, d); chk("R9 bit9 matches irq", {31'd0, d[9]}, {31'd0, lol_irq_o});
    wr(8'h04, 32'h0000_0200);
    chk("R7 ack clears", {31'd0, lol_irq_o}, 32'd0);
    rd(8'h04, d); chk("R9 bit9 after ack", {31'd0, d[9]}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R13 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule